// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block keeps wall-clock time and a full calendar in packed BCD. It advances once per pulse of a one-per-second tick input. The calendar covers seconds, minutes, a 24-hour hour count, a weekday counter, day of month, month, a two-digit year and a two-digit century. It applies the month-length and leap-year rules itself, so software never has to correct the date.

Two copies of the time are held. The working copy counts on every enabled tick. A second copy is the one software reads, and it normally follows the working copy. Software can set a freeze bit so that the readable copy stops changing while it reads several fields. Counting continues underneath, and the readable copy catches up as soon as the freeze is released. An enable input gates the tick, and a battery-low input is shown as a read-only flag.

Register access uses a byte-wide write port and a separate combinational read port. Both ports use the same 4-bit address map.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the time reads 00:00:00, weekday 1, date 01, month 01, year 00, century 20, and the freeze bit reads 0.
- R2: Register map, all values packed BCD. Address 0 holds seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year and 7 century. Address 8 is control, with bit 0 as the freeze bit. Address 9 is flags, with bit 0 equal to the battery-low input. Every other bit of addresses 8 and 9, and every bit of addresses 10 to 15, reads 0.
- R3: Seconds and minutes count 00 to 59, and hours count 00 to 23. Each field wraps to 00 and carries into the next field.
- R4: The weekday counts 1 to 7. It advances at every midnight, wrapping from 7 to 1, and does not depend on the date.
- R5: The date wraps to 01 and the month advances after day 30 of months 04, 06, 09 and 11, after day 31 of all other months except 02, and after day 28 of 02 in a non-leap year.
- R6: February has 29 days when the year is a multiple of 4. The exception is year 00, which is a leap year only when the century is a multiple of 4.
- R7: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and advances the century in BCD, and century 99 wraps to 00.
- R8: A tick is counted only while the oscillator-enable input is 1. With enable at 0, both copies hold their values.
- R9: While the freeze bit is 1, the readable copy holds its value and ticks still advance the working copy.
- R10: When a write clears the freeze bit, the readable copy still shows the frozen value after that write's edge. One clock later it shows the working time.
- R11: A write to address 0 to 7 loads that field into both copies on the same edge. A tick in the same cycle is dropped, and counting continues from the written value.
- R12: Writes to the flags register are ignored. It always reads the battery-low input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse, once per second |
| oscEn | input | 1 | Oscillator enable; gates secTick |
| battLow | input | 1 | Battery-below-threshold indication |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 4 | Read address |
| rdData | output | 8 | Combinational read data |

## Verification
The hardest states to reach are the calendar boundaries. These include the last second of a century, 28 February in century years that are and are not leap years, and the 9999-to-0000 wrap. Ticking from reset would need far too many cycles to reach any of them. The bench therefore writes the time registers to the second before each boundary and then sends a single tick. The working copy is hidden while frozen, so the bench freezes, sends ticks, and then releases. This exposes whether counting went on underneath. Long random runs then mix ticks, gaps in the enable, freezes and field writes.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 4;
  localparam int NUM_FIELDS = 8;
  localparam int FIELD_W    = $clog2(NUM_FIELDS);

  localparam int SEC_I   = 0;
  localparam int MIN_I   = 1;
  localparam int HOUR_I  = 2;
  localparam int DOW_I   = 3;
  localparam int DATE_I  = 4;
  localparam int MONTH_I = 5;
  localparam int YEAR_I  = 6;
  localparam int CENT_I  = 7;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(9);

  typedef logic [NUM_FIELDS-1:0][DATA_W-1:0] timeSet_t;

  // century 20, year 00, month 01, date 01, weekday 1, 00:00:00
  localparam timeSet_t RESET_TIME = {8'h20, 8'h00, 8'h01, 8'h01,
                                     8'h01, 8'h00, 8'h00, 8'h00};

  typedef struct packed {
    logic               advance;
    logic               copy;
    logic               load;
    logic [FIELD_W-1:0] field;
    logic [DATA_W-1:0]  data;
  } calStrobe_t;
endpackage

// File: rtl/cal_ctrl.sv
`timescale 1ns/1ps
module cal_ctrl
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              oscEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output calStrobe_t        strobe,
  output logic              freezeQ
);
  logic timeWrite;
  logic ctrlWrite;

  assign timeWrite = wrEn && (wrAddr < ADDR_W'(NUM_FIELDS));
  assign ctrlWrite = wrEn && (wrAddr == CTRL_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN)          freezeQ <= 1'b0;
    else if (ctrlWrite) freezeQ <= wrData[0];
  end

  always_comb begin
    strobe.advance = oscEn && secTick && !timeWrite;
    strobe.copy    = !freezeQ;
    strobe.load    = timeWrite;
    strobe.field   = wrAddr[FIELD_W-1:0];
    strobe.data    = wrData;
  end

  // R9
  freeze_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrite |=> freezeQ == $past(wrData[0]));

  // R8
  osc_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !oscEn |-> !strobe.advance);
endmodule

// File: rtl/cal_datapath.sv
`timescale 1ns/1ps
module cal_datapath
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  calStrobe_t strobe,
  output timeSet_t   userTime
);
  timeSet_t intQ, intNext;
  timeSet_t userQ, userNext;
  logic     leapYear;

  function automatic logic [DATA_W-1:0] bcdInc(input logic [DATA_W-1:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcdToBin(input logic [DATA_W-1:0] v);
    return ({3'b000, v[7:4]} * 7'd10) + {3'b000, v[3:0]};
  endfunction

  function automatic logic isLeap(input logic [DATA_W-1:0] yr,
                                  input logic [DATA_W-1:0] cent);
    logic [6:0] yb, cb;
    yb = bcdToBin(yr);
    cb = bcdToBin(cent);
    return (yb[1:0] == 2'b00) && ((yb != 7'd0) || (cb[1:0] == 2'b00));
  endfunction

  function automatic logic [DATA_W-1:0] monthLast(input logic [DATA_W-1:0] mon,
                                                  input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  assign leapYear = isLeap(intQ[YEAR_I], intQ[CENT_I]);

  always_comb begin
    intNext = intQ;
    if (strobe.load) begin
      intNext[strobe.field] = strobe.data;
    end else if (strobe.advance) begin
      if (intQ[SEC_I] != 8'h59) intNext[SEC_I] = bcdInc(intQ[SEC_I]);
      else begin
        intNext[SEC_I] = 8'h00;
        if (intQ[MIN_I] != 8'h59) intNext[MIN_I] = bcdInc(intQ[MIN_I]);
        else begin
          intNext[MIN_I] = 8'h00;
          if (intQ[HOUR_I] != 8'h23) intNext[HOUR_I] = bcdInc(intQ[HOUR_I]);
          else begin
            intNext[HOUR_I] = 8'h00;
            intNext[DOW_I]  = (intQ[DOW_I] == 8'h07) ? 8'h01 : bcdInc(intQ[DOW_I]);
            if (intQ[DATE_I] != monthLast(intQ[MONTH_I], leapYear))
              intNext[DATE_I] = bcdInc(intQ[DATE_I]);
            else begin
              intNext[DATE_I] = 8'h01;
              if (intQ[MONTH_I] != 8'h12) intNext[MONTH_I] = bcdInc(intQ[MONTH_I]);
              else begin
                intNext[MONTH_I] = 8'h01;
                if (intQ[YEAR_I] != 8'h99) intNext[YEAR_I] = bcdInc(intQ[YEAR_I]);
                else begin
                  intNext[YEAR_I] = 8'h00;
                  intNext[CENT_I] = (intQ[CENT_I] == 8'h99) ? 8'h00
                                                            : bcdInc(intQ[CENT_I]);
                end
              end
            end
          end
        end
      end
    end
  end

  always_comb begin
    userNext = userQ;
    if (strobe.copy)      userNext = intNext;
    else if (strobe.load) userNext[strobe.field] = strobe.data;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intQ  <= RESET_TIME;
      userQ <= RESET_TIME;
    end else begin
      intQ  <= intNext;
      userQ <= userNext;
    end
  end

  assign userTime = userQ;

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && intQ[SEC_I] == 8'h59) |=> intQ[SEC_I] == 8'h00);

  // R4
  dow_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && intQ[SEC_I] == 8'h59 && intQ[MIN_I] == 8'h59 &&
     intQ[HOUR_I] == 8'h23 && intQ[DOW_I] == 8'h07) |=> intQ[DOW_I] == 8'h01);

  // R7
  year_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && intQ[YEAR_I] == 8'h99 && intQ[MONTH_I] == 8'h12 &&
     intQ[DATE_I] == 8'h31 && intQ[HOUR_I] == 8'h23 && intQ[MIN_I] == 8'h59 &&
     intQ[SEC_I] == 8'h59) |=> (intQ[YEAR_I] == 8'h00 && intQ[MONTH_I] == 8'h01 &&
     intQ[CENT_I] != $past(intQ[CENT_I])));

  // R8
  int_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance && !strobe.load) |=> intQ == $past(intQ));

  // R9
  user_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.copy && !strobe.load) |=> userQ == $past(userQ));
endmodule

// File: rtl/bcd_calendar_clock.sv
`timescale 1ns/1ps
module bcd_calendar_clock
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              oscEn,
  input  logic              battLow,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  calStrobe_t strobe;
  logic       freezeQ;
  timeSet_t   userTime;

  cal_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .secTick (secTick),
    .oscEn   (oscEn),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .strobe  (strobe),
    .freezeQ (freezeQ)
  );

  cal_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .userTime (userTime)
  );

  always_comb begin
    if (rdAddr < ADDR_W'(NUM_FIELDS)) rdData = userTime[rdAddr[FIELD_W-1:0]];
    else if (rdAddr == CTRL_ADDR)     rdData = {{(DATA_W-1){1'b0}}, freezeQ};
    else if (rdAddr == FLAG_ADDR)     rdData = {{(DATA_W-1){1'b0}}, battLow};
    else                              rdData = '0;
  end

  // R12
  flag_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == FLAG_ADDR) |-> (rdData[0] == battLow && rdData[DATA_W-1:1] == '0));
endmodule

// File: tb/bcd_calendar_clock_tb.sv
`timescale 1ns/1ps
module bcd_calendar_clock_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       secTick = 1'b0;
  logic       oscEn = 1'b1;
  logic       battLow = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [3:0] rdAddr = '0;
  logic [7:0] rdData;

  logic [7:0] mInt  [8];
  logic [7:0] mUser [8];
  bit         mFreeze;
  int         errors = 0;
  int         checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_calendar_clock u_dut (
    .clk(clk), .rstN(rstN), .secTick(secTick), .oscEn(oscEn),
    .battLow(battLow), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  function automatic int b2i(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int daysIn(input int mon, input int fullYear);
    bit lp;
    lp = ((fullYear % 4 == 0) && (fullYear % 100 != 0)) || (fullYear % 400 == 0);
    if (mon == 2) return lp ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic modelTick();
    int s, mi, h, dw, d, mo, y, c;
    s = b2i(mInt[0]); mi = b2i(mInt[1]); h = b2i(mInt[2]); dw = b2i(mInt[3]);
    d = b2i(mInt[4]); mo = b2i(mInt[5]); y = b2i(mInt[6]); c = b2i(mInt[7]);
    s++;
    if (s == 60) begin
      s = 0; mi++;
      if (mi == 60) begin
        mi = 0; h++;
        if (h == 24) begin
          h = 0; dw = dw % 7 + 1; d++;
          if (d > daysIn(mo, c * 100 + y)) begin
            d = 1; mo++;
            if (mo > 12) begin
              mo = 1; y++;
              if (y == 100) begin y = 0; c = (c + 1) % 100; end
            end
          end
        end
      end
    end
    mInt[0] = i2b(s); mInt[1] = i2b(mi); mInt[2] = i2b(h); mInt[3] = i2b(dw);
    mInt[4] = i2b(d); mInt[5] = i2b(mo); mInt[6] = i2b(y); mInt[7] = i2b(c);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input bit tk, input bit osc, input bit we,
                      input logic [3:0] wa, input logic [7:0] wd);
    bit frzOld, tw;
    secTick = tk; oscEn = osc; wrEn = we; wrAddr = wa; wrData = wd;
    @(posedge clk);
    frzOld = mFreeze;
    tw = we && (wa < 4'd8);
    if (tw) mInt[wa[2:0]] = wd;
    else if (tk && osc) modelTick();
    if (!frzOld) mUser = mInt;
    else if (tw) mUser[wa[2:0]] = wd;
    if (we && wa == 4'd8) mFreeze = wd[0];
    @(negedge clk);
    secTick = 1'b0; wrEn = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b0, 4'd0, 8'h00);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    step(1'b0, 1'b1, 1'b1, a, d);
  endtask

  task automatic setTime(input int c, input int y, input int mo, input int d,
                         input int dw, input int h, input int mi, input int s);
    wr(4'd7, i2b(c)); wr(4'd6, i2b(y)); wr(4'd5, i2b(mo)); wr(4'd4, i2b(d));
    wr(4'd3, i2b(dw)); wr(4'd2, i2b(h)); wr(4'd1, i2b(mi)); wr(4'd0, i2b(s));
  endtask

  task automatic checkReg(input string tag, input logic [3:0] a, input logic [7:0] exp);
    rdAddr = a;
    #0.2;
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rdData, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    for (int a = 0; a < 8; a++) checkReg(tag, 4'(a), mUser[a]);
    checkReg(tag, 4'd8, {7'b0, mFreeze});
    checkReg(tag, 4'd9, {7'b0, battLow});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240229));
    mInt = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h20};
    mUser = mInt;
    mFreeze = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkAll("R1");

    // R2: unused addresses and flag bit
    for (int a = 10; a < 16; a++) checkReg("R2", 4'(a), 8'h00);
    battLow = 1'b1; checkReg("R2", 4'd9, 8'h01);

    // R12: writes to flags ignored
    wr(4'd9, 8'hFE); checkReg("R12", 4'd9, 8'h01);
    battLow = 1'b0; wr(4'd9, 8'hFF); checkReg("R12", 4'd9, 8'h00);
    checkAll("R12");

    // R3
    setTime(20, 24, 3, 15, 2, 10, 58, 58);
    tick(1); checkAll("R3");
    tick(1); checkAll("R3");
    setTime(20, 24, 3, 15, 2, 22, 59, 59);
    tick(1); checkAll("R3");

    // R4: weekday wraps regardless of date
    setTime(20, 24, 3, 15, 7, 23, 59, 59);
    tick(1); checkAll("R4");

    // R5
    setTime(20, 23, 4, 30, 3, 23, 59, 59); tick(1); checkAll("R5");
    setTime(20, 23, 2, 28, 3, 23, 59, 59); tick(1); checkAll("R5");
    setTime(20, 23, 1, 31, 3, 23, 59, 59); tick(1); checkAll("R5");
    setTime(20, 23, 11, 30, 3, 23, 59, 59); tick(1); checkAll("R5");

    // R6
    setTime(20, 24, 2, 28, 1, 23, 59, 59); tick(1); checkAll("R6");
    tick(86400 / 86400 * 0); // keep structure simple
    setTime(20, 24, 2, 29, 1, 23, 59, 59); tick(1); checkAll("R6");
    setTime(20, 0, 2, 28, 1, 23, 59, 59); tick(1); checkAll("R6");
    setTime(21, 0, 2, 28, 1, 23, 59, 59); tick(1); checkAll("R6");
    setTime(19, 0, 2, 28, 1, 23, 59, 59); tick(1); checkAll("R6");

    // R7
    setTime(20, 99, 12, 31, 5, 23, 59, 59); tick(1); checkAll("R7");
    setTime(99, 99, 12, 31, 5, 23, 59, 59); tick(1); checkAll("R7");

    // R8: disabled oscillator holds both copies
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 4'd0, 8'h00);
    checkAll("R8");
    tick(2); checkAll("R8");

    // R9 and R10: freeze, count underneath, release
    wr(4'd8, 8'h01); checkAll("R9");
    tick(7); checkAll("R9");
    wr(4'd8, 8'h00); checkAll("R10");
    step(1'b0, 1'b1, 1'b0, 4'd0, 8'h00); checkAll("R10");

    // R11: write with simultaneous tick; tick dropped
    step(1'b1, 1'b1, 1'b1, 4'd0, 8'h30); checkAll("R11");
    tick(1); checkAll("R11");
    wr(4'd8, 8'h01);
    step(1'b1, 1'b1, 1'b1, 4'd1, 8'h45); checkAll("R11");
    wr(4'd8, 8'h00); step(1'b0, 1'b1, 1'b0, 4'd0, 8'h00); checkAll("R11");

    // Random mix (R3 R8 R9 R11)
    setTime(20, 99, 12, 31, 7, 23, 10, 0);
    for (int i = 0; i < 6000; i++) begin
      bit tk, osc, we;
      logic [3:0] wa;
      logic [7:0] wd;
      int sel;
      tk  = ($urandom % 3) != 0;
      osc = ($urandom % 8) != 0;
      we  = ($urandom % 12) == 0;
      sel = $urandom % 6;
      case (sel)
        0: begin wa = 4'd0; wd = i2b($urandom % 60); end
        1: begin wa = 4'd1; wd = i2b($urandom % 60); end
        2: begin wa = 4'd2; wd = i2b($urandom % 24); end
        3: begin wa = 4'd3; wd = i2b(1 + $urandom % 7); end
        4: begin wa = 4'd8; wd = 8'($urandom % 2); end
        default: begin wa = 4'd9; wd = 8'($urandom); end
      endcase
      if (($urandom % 50) == 0) battLow = ~battLow;
      step(tk, osc, we, wa, wd);
      checkAll("R3");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule